// File: doc/BRIEF.md
# Waveform Timer Channel

This block is a single up-counting timer channel that produces two output waveforms, A and B. Three compare values set the timing. The RC value can close the period by sending the counter back to zero. The other two compare values, RA and RB, place edges inside that period. Each output has a small action table. That table says what happens to the output (nothing, drive high, drive low, or invert) when one of the following events occurs: its own compare match, an RC match, an external event, or a trigger. With this arrangement the channel covers dual PWM, single pulses and programmable delays.

The count rate comes from a power-of-two prescaler. A trigger zeroes the counter and starts it running. A trigger can come from a software strobe, from a broadcast sync strobe, or, when enabled, from the external event. The external event is an edge on one of four inputs: the B pin itself, or one of three auxiliary lines. While the B pin is chosen as the event source, its output driver is released so that it works as an input. Every compare match also raises a one-cycle interrupt pulse.

Top module: `wave_timer_channel`

## Requirements
- R1: After reset both outputs are low, the counter reads 0, the interrupt is low and the counter does not advance until it is both enabled and triggered.
- R2: The counter advances by one on each prescaler tick only while the clock-enable state is on and the channel has been started. A clkEn strobe turns the enable state on and a clkDis strobe turns it off. A trigger given while the enable state is off leaves the counter at 0.
- R3: A trigger (swTrg, syncIn, or the external event when extTrigEn is 1) forces the counter to 0 at that edge and starts it counting. The trigger also applies the trigger action field to each output.
- R4: Each action field is 2 bits: 0 none, 1 set, 2 clear, 3 toggle. In actA and actB, bits [1:0] belong to the output's own compare match (RA for A, RB for B), bits [3:2] to the RC match, bits [5:4] to the external event and bits [7:6] to swTrg/syncIn.
- R5: With rcTrigEn = 1 the counter wraps from rc to 0, so the period is rc+1 ticks. With set-on-trigger, set-on-RC and clear-on-RA, output A is high for ra+1 ticks of each period.
- R6: A compare value above rc never matches while rcTrigEn is 1, so its action never fires.
- R7: When several events fall in the same cycle, the output takes the action of the highest-priority event whose field is not none. The order from highest to lowest is: software or sync trigger, external event, RC match, own compare match.
- R8: An RC match with rcStop = 1 stops the counter. An RC match with rcDisable = 1 turns the clock-enable state off, so later triggers do not restart counting until clkEn is strobed.
- R9: extSel chooses the event source (0 = B pin, 1..3 = xcIn[0..2]). extEdge chooses the edge (1 rising, 2 falling, 3 both, 0 none). An accepted edge applies its action at the first clock edge after the input changes, and edges of the wrong direction or on unselected inputs have no effect.
- R10: tiobOe is 0 exactly when extSel = 0, and 1 otherwise.
- R11: Counting happens once every 2^clkSel clocks, and the prescaler restarts on each trigger.
- R12: irqOut is high for one cycle following each RA, RB or RC compare match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| clkEn | input | 1 | Strobe: turn the counting clock on |
| clkDis | input | 1 | Strobe: turn the counting clock off |
| swTrg | input | 1 | Strobe: software trigger |
| syncIn | input | 1 | Strobe: broadcast sync trigger |
| clkSel | input | 2 | Prescaler select, divide by 2^clkSel |
| extSel | input | 2 | External event source select |
| extEdge | input | 2 | External event edge select |
| extTrigEn | input | 1 | External event also acts as a trigger |
| rcTrigEn | input | 1 | RC match resets the counter |
| rcStop | input | 1 | RC match stops the counter |
| rcDisable | input | 1 | RC match turns the counting clock off |
| actA | input | 8 | Action fields for output A |
| actB | input | 8 | Action fields for output B |
| ra | input | CNT_W | Compare value for A |
| rb | input | CNT_W | Compare value for B |
| rc | input | CNT_W | Period compare value |
| xcIn | input | 3 | Auxiliary event lines |
| tiobIn | input | 1 | B pin input value |
| tioaOut | output | 1 | Waveform A |
| tiobOut | output | 1 | Waveform B |
| tiobOe | output | 1 | Output enable for the B pin |
| irqOut | output | 1 | Compare-match interrupt pulse |
| cntOut | output | CNT_W | Counter value |

## Verification
The PWM function is driven with a table of compare sets. The rows cover compare values inside the period, a compare value of zero, a compare value beyond RC, compare values equal to RC, and toggle actions in place of set/clear. The high time counted over one period therefore separates off-by-one errors in the period and in the compare points, a missing wrap, and a wrong priority between RC and the output's own compare. Directed cases then place a trigger on the same edge as a compare match, an edge of each direction on selected and unselected event inputs, and the stop, disable and prescaler settings. These cases separate the trigger sources and the event qualification.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic run;       // counting allowed (enabled and started)
    logic clear;     // force counter to zero
    logic preClear;  // restart prescaler
  } dp_strobe_t;

  function automatic logic applyAct(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic [1:0]       clkSel,
  input  logic [CNT_W-1:0] ra,
  input  logic [CNT_W-1:0] rb,
  input  logic [CNT_W-1:0] rc,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             matchA,
  output logic             matchB,
  output logic             matchC
);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             divTick;

  always_comb begin
    preMask = PRE_W'((32'd1 << clkSel) - 32'd1);
    divTick = (preCnt & preMask) == preMask;
    tick    = strobe.run && divTick;
    matchA  = tick && (cnt == ra);
    matchB  = tick && (cnt == rb);
    matchC  = tick && (cnt == rc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobe.preClear) begin
      preCnt <= '0;
    end else if (strobe.run) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !tick) |=> $stable(cnt));

  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (cnt == '0));

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic       clkDis,
  input  logic       swTrg,
  input  logic       syncIn,
  input  logic [1:0] extSel,
  input  logic [1:0] extEdge,
  input  logic       extTrigEn,
  input  logic       rcTrigEn,
  input  logic       rcStop,
  input  logic       rcDisable,
  input  logic [7:0] actA,
  input  logic [7:0] actB,
  input  logic [2:0] xcIn,
  input  logic       tiobIn,
  input  logic       matchA,
  input  logic       matchB,
  input  logic       matchC,
  output dp_strobe_t strobe,
  output logic       tioaOut,
  output logic       tiobOut,
  output logic       tiobOe,
  output logic       irqOut
);

  logic       clkOn;
  logic       running;
  logic       srcNow;
  logic       prevSrc;
  logic       extEv;
  logic       swEv;
  logic       trig;
  logic [1:0] outBits;
  logic [1:0] ownMatch;
  logic [7:0] actFld [2];

  always_comb begin
    srcNow = (extSel == 2'd0) ? tiobIn : xcIn[extSel - 2'd1];
    extEv  = (extEdge[0] && !prevSrc && srcNow) ||
             (extEdge[1] && prevSrc && !srcNow);
    swEv   = swTrg || syncIn;
    trig   = swEv || (extEv && extTrigEn);
    strobe.run      = clkOn && running;
    strobe.clear    = trig || (matchC && rcTrigEn);
    strobe.preClear = trig;
  end

  assign ownMatch  = {matchB, matchA};
  assign actFld[0] = actA;
  assign actFld[1] = actB;

  for (genvar o = 0; o < 2; o++) begin : g_out
    act_e sel;
    logic q;
    always_comb begin
      if (swEv && act_e'(actFld[o][7:6]) != ACT_NONE)
        sel = act_e'(actFld[o][7:6]);
      else if (extEv && act_e'(actFld[o][5:4]) != ACT_NONE)
        sel = act_e'(actFld[o][5:4]);
      else if (matchC && act_e'(actFld[o][3:2]) != ACT_NONE)
        sel = act_e'(actFld[o][3:2]);
      else if (ownMatch[o] && act_e'(actFld[o][1:0]) != ACT_NONE)
        sel = act_e'(actFld[o][1:0]);
      else
        sel = ACT_NONE;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else       q <= applyAct(sel, q);
    end
    assign outBits[o] = q;
  end

  assign tioaOut = outBits[0];
  assign tiobOut = outBits[1];
  assign tiobOe  = (extSel != 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkOn   <= 1'b0;
      running <= 1'b0;
      prevSrc <= 1'b0;
      irqOut  <= 1'b0;
    end else begin
      prevSrc <= srcNow;
      irqOut  <= matchA || matchB || matchC;
      if (clkDis || (matchC && rcDisable)) clkOn <= 1'b0;
      else if (clkEn)                      clkOn <= 1'b1;
      if (trig)                   running <= 1'b1;
      else if (matchC && rcStop)  running <= 1'b0;
    end
  end

  // R12
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchA || matchB || matchC) |=> irqOut);

  // R8
  rc_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchC && rcStop && !trig) |=> !running);

  // R7
  sw_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swEv && actA[7:6] == 2'd1) |=> tioaOut);

endmodule

// File: rtl/wave_timer_channel.sv
module wave_timer_channel
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             clkDis,
  input  logic             swTrg,
  input  logic             syncIn,
  input  logic [1:0]       clkSel,
  input  logic [1:0]       extSel,
  input  logic [1:0]       extEdge,
  input  logic             extTrigEn,
  input  logic             rcTrigEn,
  input  logic             rcStop,
  input  logic             rcDisable,
  input  logic [7:0]       actA,
  input  logic [7:0]       actB,
  input  logic [CNT_W-1:0] ra,
  input  logic [CNT_W-1:0] rb,
  input  logic [CNT_W-1:0] rc,
  input  logic [2:0]       xcIn,
  input  logic             tiobIn,
  output logic             tioaOut,
  output logic             tiobOut,
  output logic             tiobOe,
  output logic             irqOut,
  output logic [CNT_W-1:0] cntOut
);

  dp_strobe_t strobe;
  logic       tick;
  logic       matchA;
  logic       matchB;
  logic       matchC;

  wtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .clkDis(clkDis),
    .swTrg(swTrg), .syncIn(syncIn), .extSel(extSel), .extEdge(extEdge),
    .extTrigEn(extTrigEn), .rcTrigEn(rcTrigEn), .rcStop(rcStop),
    .rcDisable(rcDisable), .actA(actA), .actB(actB), .xcIn(xcIn),
    .tiobIn(tiobIn), .matchA(matchA), .matchB(matchB), .matchC(matchC),
    .strobe(strobe), .tioaOut(tioaOut), .tiobOut(tiobOut),
    .tiobOe(tiobOe), .irqOut(irqOut)
  );

  wtc_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clkSel(clkSel),
    .ra(ra), .rb(rb), .rc(rc), .cnt(cntOut), .tick(tick),
    .matchA(matchA), .matchB(matchB), .matchC(matchC)
  );

endmodule

// File: tb/wave_timer_channel_bench.sv
`timescale 1ns/1ps
module wave_timer_channel_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 0, clkDis = 0, swTrg = 0, syncIn = 0;
  logic [1:0] clkSel = 0, extSel = 0, extEdge = 0;
  logic extTrigEn = 0, rcTrigEn = 0, rcStop = 0, rcDisable = 0;
  logic [7:0] actA = 0, actB = 0;
  logic [15:0] ra = 0, rb = 0, rc = 0;
  logic [2:0] xcIn = 0;
  logic tiobIn = 0;
  logic tioaOut, tiobOut, tiobOe, irqOut;
  logic [15:0] cntOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wave_timer_channel u_wave_timer_channel (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .clkDis(clkDis), .swTrg(swTrg),
    .syncIn(syncIn), .clkSel(clkSel), .extSel(extSel), .extEdge(extEdge),
    .extTrigEn(extTrigEn), .rcTrigEn(rcTrigEn), .rcStop(rcStop),
    .rcDisable(rcDisable), .actA(actA), .actB(actB), .ra(ra), .rb(rb),
    .rc(rc), .xcIn(xcIn), .tiobIn(tiobIn), .tioaOut(tioaOut),
    .tiobOut(tiobOut), .tiobOe(tiobOe), .irqOut(irqOut), .cntOut(cntOut)
  );

  typedef struct packed {
    logic [15:0] vRa;
    logic [15:0] vRb;
    logic [15:0] vRc;
    logic [7:0]  vActA;
    logic [7:0]  vActB;
    logic [15:0] hiA;
    logic [15:0] hiB;
  } vec_t;

  // actA 8'h46: trig set, RC set, RA clear; 8'h4F: trig set, RC/RA toggle
  // actB 8'h89: trig clear, RC clear, RB set
  localparam vec_t VECS [5] = '{
    '{16'd3,  16'd5, 16'd9,  8'h46, 8'h89, 16'd4,  16'd4},
    '{16'd0,  16'd0, 16'd7,  8'h46, 8'h89, 16'd1,  16'd7},
    '{16'd12, 16'd2, 16'd10, 8'h46, 8'h89, 16'd11, 16'd8},
    '{16'd6,  16'd6, 16'd6,  8'h46, 8'h89, 16'd7,  16'd0},
    '{16'd4,  16'd1, 16'd15, 8'h4F, 8'h89, 16'd5,  16'd14}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic trigger();
    swTrg = 1'b1;
    @(negedge clk);
    swTrg = 1'b0;
  endtask

  task automatic strobeEnable();
    clkEn = 1'b1;
    @(negedge clk);
    clkEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hA, hB, irqs;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    check("R1 tioa", tioaOut, 0);
    check("R1 tiob", tiobOut, 0);
    check("R1 irq", irqOut, 0);
    waitN(5);
    check("R1 cnt idle", cntOut, 0);
    check("R10 oe with B pin as source", tiobOe, 0);

    // R2: trigger while clock off does not count
    rcTrigEn = 1; rc = 16'd1000; extSel = 2'd1;
    trigger();
    waitN(5);
    check("R2 no count when disabled", cntOut, 0);
    strobeEnable();
    waitN(5);
    check("R2 count after enable", cntOut, 5);
    check("R10 oe with aux source", tiobOe, 1);

    // R4 R5 R6 R7 PWM table
    for (int i = 0; i < 5; i++) begin
      ra = VECS[i].vRa; rb = VECS[i].vRb; rc = VECS[i].vRc;
      actA = VECS[i].vActA; actB = VECS[i].vActB;
      trigger();
      hA = 0; hB = 0;
      for (int j = 0; j <= int'(rc); j++) begin
        hA += int'(tioaOut);
        hB += int'(tiobOut);
        @(negedge clk);
      end
      check($sformatf("R5 row%0d A high", i), hA, int'(VECS[i].hiA));
      check($sformatf("R5 row%0d B high", i), hB, int'(VECS[i].hiB));
    end

    // R7: trigger beats RA compare in the same cycle
    ra = 16'd4; rc = 16'd20; actA = 8'h46;
    trigger();
    waitN(4);
    swTrg = 1'b1;
    @(negedge clk);
    swTrg = 1'b0;
    check("R7 trigger over RA", tioaOut, 1);
    check("R3 cnt zero after trigger", cntOut, 0);

    // R12 interrupt pulses
    ra = 16'd2; rb = 16'd5; rc = 16'd8;
    trigger();
    irqs = 0;
    for (int j = 0; j <= 8; j++) begin
      irqs += int'(irqOut);
      @(negedge clk);
    end
    check("R12 pulses for RA and RB", irqs, 2);
    check("R12 pulse after RC", irqOut, 1);

    // R8 stop and disable on RC
    rcTrigEn = 0; rcStop = 1; rc = 16'd6;
    trigger();
    waitN(20);
    check("R8 stopped after RC", cntOut, 7);
    rcStop = 0; rcTrigEn = 1; rcDisable = 1;
    trigger();
    waitN(20);
    trigger();
    waitN(5);
    check("R8 disabled after RC", cntOut, 0);
    strobeEnable();
    waitN(3);
    check("R8 counts after re-enable", cntOut, 3);
    rcDisable = 0; rc = 16'd1000;

    // R11 prescaler
    clkSel = 2'd2;
    trigger();
    waitN(40);
    check("R11 divide by 4", cntOut, 10);
    clkSel = 2'd3;
    trigger();
    waitN(40);
    check("R11 divide by 8", cntOut, 5);
    clkSel = 2'd0;

    // R9 external event: sw set, ext toggle
    actA = 8'h70; extSel = 2'd1; extEdge = 2'd1;
    trigger();
    xcIn[0] = 1'b1;
    @(negedge clk);
    check("R9 rising toggles", tioaOut, 0);
    xcIn[0] = 1'b0;
    @(negedge clk);
    check("R9 falling ignored", tioaOut, 0);
    extEdge = 2'd3;
    xcIn[0] = 1'b1;
    @(negedge clk);
    check("R9 both edges rise", tioaOut, 1);
    xcIn[0] = 1'b0;
    @(negedge clk);
    check("R9 both edges fall", tioaOut, 0);
    extSel = 2'd2;
    @(negedge clk);
    xcIn[0] = 1'b1;
    @(negedge clk);
    check("R9 unselected ignored", tioaOut, 0);
    xcIn[1] = 1'b1;
    @(negedge clk);
    check("R9 selected line toggles", tioaOut, 1);

    // R3 external trigger
    extEdge = 2'd1;
    xcIn = 3'b000;
    @(negedge clk);
    extTrigEn = 1;
    waitN(5);
    xcIn[1] = 1'b1;
    @(negedge clk);
    check("R3 ext trigger clears", cntOut, 0);
    waitN(3);
    check("R3 counts after ext trigger", cntOut, 3);
    extTrigEn = 0;

    // R3 sync acts as trigger with sw action
    actA = 8'h40;
    trigger();
    actA = 8'h80;
    waitN(5);
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    check("R3 sync clears cnt", cntOut, 0);
    check("R3 sync applies action", tioaOut, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule